// File: doc/BRIEF.md
# Write Start Qualifier

This block sits between the control pins of a byte-wide nonvolatile memory and its internal write engine. It watches a digital supply-good flag and the active-low chip-enable, output-enable and write-enable pins. It emits a one-cycle `write_start` pulse only when a write strobe is genuinely legal: the supply is good, the power-on hold-off has expired, the pin combination requests a write, and the combined strobe has stayed active long enough not to be a glitch.

All pins cross into the clock domain through a two-stage synchronizer. A saturating timer counts clock cycles of continuous supply-good. Any cycle with the flag low clears the timer, so the hold-off starts again from zero. The write request is the AND of the expired timer and the legal pin combination (chip-enable low, output-enable high, write-enable low). A second saturating counter measures how long that request has been continuously true. It fires exactly once, on the cycle the run length reaches the minimum strobe width. Both durations are parameters in clock cycles. The asynchronous reset is released through a two-flop reset synchronizer.

Top module: `write_start_gate`

## Requirements
- R1: While `supply_ok` is low, `write_start` never asserts, whatever the control pins do.
- R2: With `ce_n`=0, `oe_n`=1 and `we_n`=0 held steady, `write_start` pulses exactly POR_CYCLES+MIN_WIDTH+1 clock edges after the first edge that samples `supply_ok` high.
- R3: A low period of `supply_ok`, even a single cycle, restarts the hold-off, so the R2 delay is measured from the last rise.
- R4: Each of `oe_n`=0, `ce_n`=1 and `we_n`=1 alone vetoes a write. Only the combination `ce_n`=0, `oe_n`=1, `we_n`=0 gives a pulse.
- R5: An active strobe on `we_n` or `ce_n` that lasts fewer than MIN_WIDTH cycles starts no write. One lasting MIN_WIDTH cycles or more starts exactly one write.
- R6: `write_start` is one cycle wide and fires once per strobe, however long the strobe is held.
- R7: Once the hold-off has expired, `write_start` pulses MIN_WIDTH+1 edges after the first edge that samples the pin level completing a legal write combination.
- R8: `write_start` is low during reset. After `rst_n` rises, the hold-off restarts, and with supply and pins held in the write state, the pulse comes POR_CYCLES+MIN_WIDTH+3 edges after the first edge that samples `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Qualifier clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Digital supply-good flag from the comparator |
| ce_n | input | 1 | Chip-enable pin, active low |
| oe_n | input | 1 | Output-enable pin, active low |
| we_n | input | 1 | Write-enable pin, active low |
| write_start | output | 1 | One-cycle pulse that launches an internal write |

## Verification
The bench sweeps strobe lengths from one cycle up past the minimum width, on both `we_n` and `ce_n`. An off-by-one filter would pass a strobe one cycle short of the minimum, or drop one of exactly the minimum. It checks the exact cycle of the first pulse after a supply rise, after a one-cycle supply dip, and after reset. A hold-off timer that paused instead of restarting, or that expired one cycle early or late, shows up as a shifted pulse. All eight pin combinations are driven, and a strobe is held for a long time to catch a design that retriggers or stretches the pulse.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  typedef struct packed {
    logic supply;
    logic ce_n;
    logic oe_n;
    logic we_n;
  } wsg_pins_t;

  // Safe idle level for every synchronized pin: unpowered, all strobes inactive.
  localparam wsg_pins_t PINS_IDLE = '{supply: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/wsg_sync2.sv
module wsg_sync2 #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/wsg_holdoff.sv
module wsg_holdoff #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_s,
  output logic ready
);

  localparam int             CW  = $clog2(LIMIT + 1);
  localparam logic [CW-1:0]  LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Saturating run-length of supply-good; any low cycle clears it.
  always_comb begin
    cnt_d = cnt_q;
    if (!supply_s) begin
      cnt_d = '0;
    end else if (cnt_q != LIM) begin
      cnt_d = cnt_q + CW'(1);
    end
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready = supply_s && (cnt_q == LIM);

endmodule

// File: rtl/wsg_width_filter.sv
module wsg_width_filter #(
  parameter int MIN_WIDTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic pulse
);

  localparam int            CW   = $clog2(MIN_WIDTH + 1);
  localparam logic [CW-1:0] MINW = CW'(MIN_WIDTH);
  localparam logic [CW-1:0] LAST = CW'(MIN_WIDTH - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;
  logic          pulse_q;
  logic          pulse_d;

  // Run length saturates at MIN_WIDTH, so the crossing happens once per strobe.
  always_comb begin
    run_d = run_q;
    if (!req) begin
      run_d = '0;
    end else if (run_q != MINW) begin
      run_d = run_q + CW'(1);
    end
    run_en  = (run_d != run_q);
    pulse_d = req && (run_q == LAST);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (run_en) begin
        run_q <= run_d;
      end
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/write_start_gate.sv
module write_start_gate
  import wsg_pkg::*;
#(
  parameter int POR_CYCLES = 500000,
  parameter int MIN_WIDTH  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic write_start
);

  localparam int PIN_W = $bits(wsg_pins_t);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign arst_n = rst_pipe_q[1];

  wsg_pins_t pins_raw;
  wsg_pins_t pins_s;
  logic      sup_s;
  logic      ce_s;
  logic      oe_s;
  logic      we_s;
  logic      ready;
  logic      req;

  assign pins_raw = '{supply: supply_ok, ce_n: ce_n, oe_n: oe_n, we_n: we_n};

  wsg_sync2 #(
    .W       (PIN_W),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (pins_raw),
    .q      (pins_s)
  );

  assign sup_s = pins_s.supply;
  assign ce_s  = pins_s.ce_n;
  assign oe_s  = pins_s.oe_n;
  assign we_s  = pins_s.we_n;

  wsg_holdoff #(
    .LIMIT (POR_CYCLES)
  ) u_holdoff (
    .clk      (clk),
    .arst_n   (arst_n),
    .supply_s (sup_s),
    .ready    (ready)
  );

  // Legal write: powered and settled, chip selected, outputs off, strobe low.
  assign req = ready && !ce_s && oe_s && !we_s;

  wsg_width_filter #(
    .MIN_WIDTH (MIN_WIDTH)
  ) u_filter (
    .clk    (clk),
    .arst_n (arst_n),
    .req    (req),
    .pulse  (write_start)
  );

endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
  parameter int POR_CYCLES = 500000,
  parameter int MIN_WIDTH  = 2
) (
  input logic clk,
  input logic arst_n,
  input logic sup_s,
  input logic ce_s,
  input logic oe_s,
  input logic we_s,
  input logic ready,
  input logic req,
  input logic write_start
);

  localparam int            PW  = $clog2(POR_CYCLES + 1);
  localparam int            MW  = $clog2(MIN_WIDTH + 1);
  localparam logic [PW-1:0] PL  = PW'(POR_CYCLES);
  localparam logic [MW-1:0] ML  = MW'(MIN_WIDTH);

  logic [PW-1:0] sup_run_q;
  logic [MW-1:0] req_run_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sup_run_q <= '0;
      req_run_q <= '0;
    end else begin
      if (!sup_s)              sup_run_q <= '0;
      else if (sup_run_q != PL) sup_run_q <= sup_run_q + PW'(1);
      if (!req)                req_run_q <= '0;
      else if (req_run_q != ML) req_run_q <= req_run_q + MW'(1);
    end
  end

  p_unpowered_r1: assert property (@(posedge clk) disable iff (!arst_n)
    !sup_s |=> !write_start);

  p_holdoff_len_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ready) |-> (sup_run_q == PL));

  p_restart_r3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sup_s) |-> !ready);

  p_pin_veto_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (!oe_s || ce_s || we_s) |=> !write_start);

  p_min_width_r5: assert property (@(posedge clk) disable iff (!arst_n)
    write_start |-> (req_run_q == ML));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!arst_n)
    write_start |=> !write_start);

endmodule

bind write_start_gate wsg_checker #(
  .POR_CYCLES (POR_CYCLES),
  .MIN_WIDTH  (MIN_WIDTH)
) u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .sup_s       (sup_s),
  .ce_s        (ce_s),
  .oe_s        (oe_s),
  .we_s        (we_s),
  .ready       (ready),
  .req         (req),
  .write_start (write_start)
);

// File: tb/write_start_gate_bench.sv
module write_start_gate_bench;

  localparam int POR = 20;
  localparam int MW  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, ce_n, oe_n, we_n;
  logic write_start;

  int cyc = 0;
  int total_pulses = 0;
  int last_pulse = -1;
  int double_wide = 0;
  logic prev_ws = 1'b0;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  write_start_gate #(.POR_CYCLES(POR), .MIN_WIDTH(MW)) u_write_start_gate (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .write_start(write_start)
  );

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (write_start === 1'b1) begin
        total_pulses = total_pulses + 1;
        last_pulse = cyc;
        if (prev_ws === 1'b1) double_wide = double_wide + 1;
      end
      prev_ws = write_start;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic c, input logic o, input logic w);
    ce_n = c; oe_n = o; we_n = w;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 30000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 30000", cyc);
      finish_run();
    end
  end

  initial begin
    int base;
    int c0;
    rst_n = 1'b0;
    supply_ok = 1'b0;
    set_pins(1'b1, 1'b1, 1'b1);
    step(3);
    chk(int'(write_start), 0, "R8 output low in reset");
    rst_n = 1'b1;
    step(5);

    // R1: unpowered, legal pins held and strobed
    base = total_pulses;
    set_pins(1'b0, 1'b1, 1'b0);
    step(60);
    for (int k = 0; k < 4; k++) begin
      we_n = 1'b1; step(3); we_n = 1'b0; step(3 * MW);
    end
    chk(total_pulses - base, 0, "R1 no write while supply low");

    // R2: exact hold-off boundary with write pins held
    base = total_pulses;
    c0 = cyc;
    supply_ok = 1'b1;
    step(POR + MW + 12);
    chk(total_pulses - base, 1, "R2 one pulse after hold-off");
    chk(last_pulse, c0 + 2 + POR + MW, "R2 pulse cycle after supply rise");
    step(80);
    chk(total_pulses - base, 1, "R6 no retrigger while held");

    // R3: one-cycle supply dip during hold-off restarts the timer
    supply_ok = 1'b0;
    step(10);
    base = total_pulses;
    supply_ok = 1'b1;
    step(10);
    supply_ok = 1'b0;
    step(1);
    c0 = cyc;
    supply_ok = 1'b1;
    step(POR + MW + 12);
    chk(total_pulses - base, 1, "R3 one pulse after restarted hold-off");
    chk(last_pulse, c0 + 2 + POR + MW, "R3 pulse timed from last rise");

    // R4: all eight pin combinations, powered and settled
    set_pins(1'b1, 1'b1, 1'b1);
    step(10);
    for (int combo = 0; combo < 8; combo++) begin
      base = total_pulses;
      set_pins(combo[2], combo[1], combo[0]);
      step(3 * MW + 4);
      set_pins(1'b1, 1'b1, 1'b1);
      step(10);
      chk(total_pulses - base, (combo == 3'b010) ? 1 : 0,
          $sformatf("R4 pins ce_n=%0d oe_n=%0d we_n=%0d", combo[2], combo[1], combo[0]));
    end

    // R5/R7: strobe width sweep on we_n
    ce_n = 1'b0;
    for (int len = 1; len <= MW + 2; len++) begin
      base = total_pulses;
      c0 = cyc;
      we_n = 1'b0;
      step(len);
      we_n = 1'b1;
      step(MW + 8);
      chk(total_pulses - base, (len >= MW) ? 1 : 0, $sformatf("R5 we_n strobe len %0d", len));
      if (len >= MW) chk(last_pulse, c0 + 2 + MW, $sformatf("R7 latency we_n len %0d", len));
    end

    // R5/R7: strobe width sweep on ce_n
    ce_n = 1'b1; we_n = 1'b0;
    step(6);
    for (int len = 1; len <= MW + 2; len++) begin
      base = total_pulses;
      c0 = cyc;
      ce_n = 1'b0;
      step(len);
      ce_n = 1'b1;
      step(MW + 8);
      chk(total_pulses - base, (len >= MW) ? 1 : 0, $sformatf("R5 ce_n strobe len %0d", len));
      if (len >= MW) chk(last_pulse, c0 + 2 + MW, $sformatf("R7 latency ce_n len %0d", len));
    end

    // R6: long strobe gives one single-cycle pulse
    base = total_pulses;
    ce_n = 1'b0;
    step(100);
    ce_n = 1'b1;
    step(6);
    chk(total_pulses - base, 1, "R6 long strobe one pulse");
    chk(double_wide, 0, "R6 pulse one cycle wide");

    // R1: supply lost after ready
    base = total_pulses;
    supply_ok = 1'b0;
    step(6);
    set_pins(1'b0, 1'b1, 1'b0);
    step(40);
    set_pins(1'b1, 1'b1, 1'b1);
    step(6);
    chk(total_pulses - base, 0, "R1 no write after supply drop");

    // R8: reset restarts the hold-off
    supply_ok = 1'b1;
    step(POR + 10);
    set_pins(1'b0, 1'b1, 1'b0);
    step(2 * MW + 4);
    rst_n = 1'b0;
    step(4);
    chk(int'(write_start), 0, "R8 output low in mid-run reset");
    base = total_pulses;
    c0 = cyc;
    rst_n = 1'b1;
    step(POR + MW + 14);
    chk(total_pulses - base, 1, "R8 one pulse after reset release");
    chk(last_pulse, c0 + 4 + POR + MW, "R8 pulse cycle after reset release");

    finish_run();
  end

endmodule